// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block drives the timing side of a parallel RGB panel. It produces horizontal and vertical sync pulses, a data-enable strobe and zero-based pixel coordinates. One clock cycle is one pixel. Software programs the timing through a small bank of 32-bit registers. Each register carries a low and a high 16-bit field. Software also selects the sync polarities and an output colour-mode code that a downstream pixel formatter decodes.

Each line walks through four phases in a fixed order: sync, back porch, active, front porch. A frame walks through the same four phases, counted in lines. Timing writes land in a pending copy. That copy moves into the working copy only on the last cycle of a frame, so the frame being scanned never mixes two configurations.

A start-of-frame status bit records the first cycle of every frame. Software clears it by writing a one. The interrupt request is that bit gated by a mask, which is set and cleared through two separate write-only strobes.

Top module: `lcd_sync_gen`

## Requirements
- R1: Word 0 holds horizontal sync width minus one in bits 15:0 and vertical sync width (lines) minus one in bits 31:16; reset value 0x0000_0001 (2 pixels, 1 line).
- R2: Word 1 holds vertical front porch minus one in bits 15:0 and the vertical back porch as a plain line count, not decremented, in bits 31:16; a back porch of 0 lines is legal and skips that phase; reset value 0x0001_0000.
- R3: Word 2 holds horizontal front porch minus one in bits 15:0 and horizontal back porch minus one in bits 31:16; reset value 0x0001_0001.
- R4: Word 3 holds active width minus one in bits 15:0 and active height minus one in bits 31:16; reset value 0x0003_0007 (8 x 4).
- R5: A line lasts sync+back+active+front pixels in that order, and a frame lasts the vertical sum in lines in that order. The first cycle of a frame is the first pixel of the first sync line.
- R6: `lcd_de` is high exactly when both axes are in their active phase. `pix_x` and `pix_y` count from 0 in raster order while `lcd_de` is high and are 0 otherwise.
- R7: Word 4 bit 0 (horizontal) and bit 1 (vertical) make the corresponding sync pin active low when set, active high when clear; the change is seen on the pins the cycle after the write.
- R8: Word 4 bits 10:8 drive `out_mode` and bit 11 drives `out_dpi`, one cycle after the write.
- R9: Writes to words 0-3 change the working timing only at the end of the frame being scanned, so the current frame keeps its length.
- R10: Status (word 8 bit 0) sets on the clock edge that ends the first cycle of a frame. Writing 1 to word 8 bit 0 clears it, and writing 0 leaves it. A set in the same cycle as a clear wins.
- R11: Writing 1 to word 5 bit 0 sets the mask and writing 1 to word 6 bit 0 clears it; word 7 bit 0 reads the mask; `sof_irq` is status AND mask, and the disable strobe leaves the status untouched.
- R12: Words 0-3 read back the last written value at once, before it takes effect. Word 4 reads only its defined bits. Words 5 and 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word index |
| reg_rdata | output | 32 | Register read data (combinational) |
| lcd_hsync | output | 1 | Horizontal sync pin, polarity applied |
| lcd_vsync | output | 1 | Vertical sync pin, polarity applied |
| lcd_de | output | 1 | Data enable |
| pix_x | output | 16 | Active pixel column |
| pix_y | output | 16 | Active pixel row |
| out_mode | output | 3 | Output colour-mode code |
| out_dpi | output | 1 | Output interface-mode flag |
| sof_irq | output | 1 | Start-of-frame interrupt request |

## Verification
The raster is first scanned with the reset timing, which has a back porch of one line and small equal porches. It is then scanned with a reprogrammed timing whose vertical back porch is zero and whose horizontal porches differ from each other. The second pattern exposes a uniform minus-one decode and any swap of the low and high fields. A third frame runs with both polarities inverted, which separates the sync phase from pin polarity. A scoreboard checks every pixel coordinate in order. Per-frame counts of sync, enable and the first active cycle fix the phase order. Timing rewritten mid-frame must leave the running frame at its old length. The interrupt is exercised through set, clear, mask and unmask in separate steps, so the status and the gating can each be shown wrong alone.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } axis_phase_t;

  // register word indices
  localparam int unsigned RA_SYNC  = 0;
  localparam int unsigned RA_VERT  = 1;
  localparam int unsigned RA_HORZ  = 2;
  localparam int unsigned RA_ACT   = 3;
  localparam int unsigned RA_OCFG  = 4;
  localparam int unsigned RA_IEN   = 5;
  localparam int unsigned RA_IDIS  = 6;
  localparam int unsigned RA_IMASK = 7;
  localparam int unsigned RA_ISTAT = 8;

  localparam int unsigned N_TIMING = 4;

  // output configuration field positions
  localparam int unsigned OC_HPOL     = 0;
  localparam int unsigned OC_VPOL     = 1;
  localparam int unsigned OC_MODE_LSB = 8;
  localparam int unsigned OC_MODE_W   = 3;
  localparam int unsigned OC_DPI      = 11;

endpackage

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_sync_pkg::*;
#(
  parameter int unsigned FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [FIELD_W:0]   len_sync,
  input  logic [FIELD_W:0]   len_back,
  input  logic [FIELD_W:0]   len_act,
  input  logic [FIELD_W:0]   len_front,
  output axis_phase_t        phase,
  output logic [FIELD_W-1:0] coord,
  output logic               first,
  output logic               last
);
  localparam int unsigned LEN_W = FIELD_W + 1;

  axis_phase_t      ph_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             at_end;

  always_comb begin
    case (ph_q)
      PH_SYNC: cur_len = len_sync;
      PH_BACK: cur_len = len_back;
      PH_ACT:  cur_len = len_act;
      default: cur_len = len_front;
    endcase
  end

  assign at_end = (cnt_q == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (step) begin
      if (at_end) begin
        cnt_q <= '0;
        case (ph_q)
          PH_SYNC: ph_q <= (len_back == '0) ? PH_ACT : PH_BACK;
          PH_BACK: ph_q <= PH_ACT;
          PH_ACT:  ph_q <= PH_FRONT;
          default: ph_q <= PH_SYNC;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase = ph_q;
  assign coord = (ph_q == PH_ACT) ? cnt_q[FIELD_W-1:0] : '0;
  assign first = (ph_q == PH_SYNC) && (cnt_q == '0);
  assign last  = (ph_q == PH_FRONT) && at_end;

endmodule

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
  import lcd_sync_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 reg_we,
  input  logic [ADDR_W-1:0]                    reg_waddr,
  input  logic [2*FIELD_W-1:0]                 reg_wdata,
  input  logic [ADDR_W-1:0]                    reg_raddr,
  output logic [2*FIELD_W-1:0]                 reg_rdata,
  input  logic                                 frame_end,
  input  logic                                 irq_mask,
  input  logic                                 irq_stat,
  output logic [N_TIMING-1:0][2*FIELD_W-1:0]   sh_words,
  output logic                                 hpol,
  output logic                                 vpol,
  output logic [OC_MODE_W-1:0]                 mode,
  output logic                                 dpi
);
  localparam int unsigned DATA_W = 2 * FIELD_W;

  logic [N_TIMING-1:0][DATA_W-1:0] pend_q;
  logic [N_TIMING-1:0][DATA_W-1:0] sh_q;

  function automatic logic [DATA_W-1:0] rst_word(input int unsigned idx);
    case (idx)
      RA_SYNC: rst_word = {FIELD_W'(0), FIELD_W'(1)};
      RA_VERT: rst_word = {FIELD_W'(1), FIELD_W'(0)};
      RA_HORZ: rst_word = {FIELD_W'(1), FIELD_W'(1)};
      default: rst_word = {FIELD_W'(3), FIELD_W'(7)};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TIMING; i++) begin
        pend_q[i] <= rst_word(i);
        sh_q[i]   <= rst_word(i);
      end
    end else begin
      for (int i = 0; i < N_TIMING; i++) begin
        if (reg_we && reg_waddr == ADDR_W'(RA_SYNC + i)) pend_q[i] <= reg_wdata;
        if (frame_end) sh_q[i] <= pend_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpol <= 1'b0;
      vpol <= 1'b0;
      mode <= '0;
      dpi  <= 1'b0;
    end else if (reg_we && reg_waddr == ADDR_W'(RA_OCFG)) begin
      hpol <= reg_wdata[OC_HPOL];
      vpol <= reg_wdata[OC_VPOL];
      mode <= reg_wdata[OC_MODE_LSB +: OC_MODE_W];
      dpi  <= reg_wdata[OC_DPI];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_TIMING; i++) begin
      if (reg_raddr == ADDR_W'(RA_SYNC + i)) reg_rdata = pend_q[i];
    end
    if (reg_raddr == ADDR_W'(RA_OCFG)) begin
      reg_rdata[OC_HPOL]                   = hpol;
      reg_rdata[OC_VPOL]                   = vpol;
      reg_rdata[OC_MODE_LSB +: OC_MODE_W]  = mode;
      reg_rdata[OC_DPI]                    = dpi;
    end
    if (reg_raddr == ADDR_W'(RA_IMASK)) reg_rdata[0] = irq_mask;
    if (reg_raddr == ADDR_W'(RA_ISTAT)) reg_rdata[0] = irq_stat;
  end

  assign sh_words = sh_q;

endmodule

// File: rtl/lcd_sof_irq.sv
module lcd_sof_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic stat_clr,
  output logic mask,
  output logic stat,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 1'b0;
      stat <= 1'b0;
    end else begin
      if (mask_set)      mask <= 1'b1;
      else if (mask_clr) mask <= 1'b0;
      if (sof)           stat <= 1'b1;
      else if (stat_clr) stat <= 1'b0;
    end
  end

  assign irq = stat & mask;

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_waddr,
  input  logic [2*FIELD_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0]    reg_raddr,
  output logic [2*FIELD_W-1:0] reg_rdata,
  output logic                 lcd_hsync,
  output logic                 lcd_vsync,
  output logic                 lcd_de,
  output logic [FIELD_W-1:0]   pix_x,
  output logic [FIELD_W-1:0]   pix_y,
  output logic [OC_MODE_W-1:0] out_mode,
  output logic                 out_dpi,
  output logic                 sof_irq
);
  localparam int unsigned DATA_W = 2 * FIELD_W;
  localparam int unsigned LEN_W  = FIELD_W + 1;
  localparam int unsigned N_AXIS = 2;   // 0 = horizontal, 1 = vertical

  logic [N_TIMING-1:0][DATA_W-1:0] sh_words;
  logic hpol, vpol;
  logic irq_mask, irq_stat;
  logic sof, frame_end;

  logic [N_AXIS-1:0][LEN_W-1:0]   l_sync, l_back, l_act, l_front;
  logic [N_AXIS-1:0]              ax_step, ax_first, ax_last;
  logic [N_AXIS-1:0][FIELD_W-1:0] ax_coord;
  axis_phase_t                    ax_ph [N_AXIS];

  function automatic logic [LEN_W-1:0] plus1(input logic [FIELD_W-1:0] f);
    plus1 = {1'b0, f} + 1'b1;
  endfunction

  // field decode: every field is stored minus one, except vertical back porch
  assign l_sync[0]  = plus1(sh_words[RA_SYNC][FIELD_W-1:0]);
  assign l_sync[1]  = plus1(sh_words[RA_SYNC][DATA_W-1:FIELD_W]);
  assign l_front[1] = plus1(sh_words[RA_VERT][FIELD_W-1:0]);
  assign l_back[1]  = {1'b0, sh_words[RA_VERT][DATA_W-1:FIELD_W]};
  assign l_front[0] = plus1(sh_words[RA_HORZ][FIELD_W-1:0]);
  assign l_back[0]  = plus1(sh_words[RA_HORZ][DATA_W-1:FIELD_W]);
  assign l_act[0]   = plus1(sh_words[RA_ACT][FIELD_W-1:0]);
  assign l_act[1]   = plus1(sh_words[RA_ACT][DATA_W-1:FIELD_W]);

  for (genvar ax = 0; ax < N_AXIS; ax++) begin : g_axis
    if (ax == 0) begin : g_pix
      assign ax_step[ax] = 1'b1;
    end else begin : g_line
      assign ax_step[ax] = ax_last[ax-1];
    end

    lcd_axis_ctr #(.FIELD_W(FIELD_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (ax_step[ax]),
      .len_sync  (l_sync[ax]),
      .len_back  (l_back[ax]),
      .len_act   (l_act[ax]),
      .len_front (l_front[ax]),
      .phase     (ax_ph[ax]),
      .coord     (ax_coord[ax]),
      .first     (ax_first[ax]),
      .last      (ax_last[ax])
    );
  end

  assign sof       = ax_first[0] & ax_first[1];
  assign frame_end = ax_last[0] & ax_last[1];

  lcd_sync_regs #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .frame_end (frame_end),
    .irq_mask  (irq_mask),
    .irq_stat  (irq_stat),
    .sh_words  (sh_words),
    .hpol      (hpol),
    .vpol      (vpol),
    .mode      (out_mode),
    .dpi       (out_dpi)
  );

  lcd_sof_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (sof),
    .mask_set (reg_we && reg_waddr == ADDR_W'(RA_IEN)   && reg_wdata[0]),
    .mask_clr (reg_we && reg_waddr == ADDR_W'(RA_IDIS)  && reg_wdata[0]),
    .stat_clr (reg_we && reg_waddr == ADDR_W'(RA_ISTAT) && reg_wdata[0]),
    .mask     (irq_mask),
    .stat     (irq_stat),
    .irq      (sof_irq)
  );

  assign lcd_de    = (ax_ph[0] == PH_ACT) && (ax_ph[1] == PH_ACT);
  assign lcd_hsync = (ax_ph[0] == PH_SYNC) ^ hpol;
  assign lcd_vsync = (ax_ph[1] == PH_SYNC) ^ vpol;
  assign pix_x     = lcd_de ? ax_coord[0] : '0;
  assign pix_y     = lcd_de ? ax_coord[1] : '0;

endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk
  import lcd_sync_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               reg_we,
  input logic [ADDR_W-1:0]                  reg_waddr,
  input logic                               wbit0,
  input logic                               lcd_de,
  input logic [FIELD_W-1:0]                 pix_x,
  input logic [FIELD_W-1:0]                 pix_y,
  input logic                               sof,
  input logic                               frame_end,
  input logic                               irq_stat,
  input logic                               irq_mask,
  input logic                               sof_irq,
  input logic [N_TIMING-1:0][2*FIELD_W-1:0] sh_words
);
  assert_blank_coords_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (pix_x == '0 && pix_y == '0));

  assert_x_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_de && $past(lcd_de)) |-> (pix_x == FIELD_W'($past(pix_x) + 1'b1)));

  assert_sof_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> irq_stat);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == ADDR_W'(RA_ISTAT) && wbit0 && !sof) |=> !irq_stat);

  assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == ADDR_W'(RA_IDIS) && wbit0) |=> !sof_irq);

  assert_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !sof_irq);

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(sh_words));

endmodule

bind lcd_sync_gen lcd_sync_chk #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_waddr (reg_waddr),
  .wbit0     (reg_wdata[0]),
  .lcd_de    (lcd_de),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .sof       (sof),
  .frame_end (frame_end),
  .irq_stat  (irq_stat),
  .irq_mask  (irq_mask),
  .sof_irq   (sof_irq),
  .sh_words  (sh_words)
);

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        lcd_hsync, lcd_vsync, lcd_de, out_dpi, sof_irq;
  logic [15:0] pix_x, pix_y;
  logic [2:0]  out_mode;

  int tests = 0;
  int fails = 0;
  longint cyc = 0;
  logic [31:0] exp_q[$];
  bit sb_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_sync_gen u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
    .pix_x(pix_x), .pix_y(pix_y), .out_mode(out_mode), .out_dpi(out_dpi),
    .sof_irq(sof_irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  // stop on the negedge of the first cycle of the next frame
  task automatic wait_fs(input bit vp);
    bit prev, cur;
    prev = lcd_vsync ^ vp;
    forever begin
      @(negedge clk);
      cur = lcd_vsync ^ vp;
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  // scoreboard driver: expected coordinates of one frame, in raster order
  task automatic push_frame(input int w, input int h);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        exp_q.push_back({y[15:0], x[15:0]});
    sb_on = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_on && lcd_de) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected enable", 1, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({pix_y, pix_x} == e, "R6 coordinate", {pix_y, pix_x}, e);
      end
      if (exp_q.size() == 0) sb_on = 1'b0;
    end
  end

  // called on the negedge of a frame's first cycle; returns on the next frame's first cycle
  task automatic measure(input int hs, input int hb, input int w, input int hf,
                         input int vs, input int vb, input int h, input int vf,
                         input bit hp, input bit vp, input string tag);
    int lh, lv, fr, hc, vc, dc, fd;
    bit pv;
    lh = hs + hb + w + hf; lv = vs + vb + h + vf; fr = lh * lv;
    hc = 0; vc = 0; dc = 0; fd = -1; pv = 1'b0;
    for (int i = 0; i < fr; i++) begin
      hc += int'(lcd_hsync ^ hp);
      vc += int'(lcd_vsync ^ vp);
      if (lcd_de) begin
        dc++;
        if (fd < 0) fd = i;
      end
      pv = lcd_vsync ^ vp;
      @(negedge clk);
    end
    chk(hc == hs * lv, {tag, " R5 hsync cycles"}, hc, hs * lv);
    chk(vc == vs * lh, {tag, " R5 vsync cycles"}, vc, vs * lh);
    chk(dc == w * h, {tag, " R6 enable cycles"}, dc, w * h);
    chk(fd == (vs + vb) * lh + hs + hb, {tag, " R5 first active cycle"}, fd, (vs + vb) * lh + hs + hb);
    chk(((lcd_vsync ^ vp) == 1'b1) && !pv, {tag, " R5 frame length"}, fr, fr);
    chk(exp_q.size() == 0, {tag, " R6 all coordinates seen"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint t0;
    rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    repeat (3) @(negedge clk);

    // reset state
    chk(lcd_hsync == 1'b1, "R7 reset hsync", lcd_hsync, 1);
    chk(lcd_vsync == 1'b1, "R7 reset vsync", lcd_vsync, 1);
    chk(lcd_de == 1'b0 && pix_x == 0 && pix_y == 0, "R6 reset enable", lcd_de, 0);
    chk(sof_irq == 1'b0, "R11 reset irq", sof_irq, 0);
    rd(4'd0, d); chk(d == 32'h0000_0001, "R1 reset word", d, 32'h0000_0001);
    rd(4'd1, d); chk(d == 32'h0001_0000, "R2 reset word", d, 32'h0001_0000);
    rd(4'd2, d); chk(d == 32'h0001_0001, "R3 reset word", d, 32'h0001_0001);
    rd(4'd3, d); chk(d == 32'h0003_0007, "R4 reset word", d, 32'h0003_0007);
    rd(4'd4, d); chk(d == 32'h0, "R12 reset output config", d, 0);
    rd(4'd7, d); chk(d == 32'h0, "R11 reset mask", d, 0);
    rd(4'd8, d); chk(d == 32'h0, "R10 reset status", d, 0);
    rst_n = 1'b1;

    // default timing: 2/2/8/2 pixels, 1/1/4/1 lines
    wait_fs(1'b0);
    push_frame(8, 4);
    measure(2, 2, 8, 2, 1, 1, 4, 1, 1'b0, 1'b0, "R1 R2 R3 R4 default");

    // status latched while masked
    rd(4'd8, d); chk(d == 32'h1, "R10 status after frame", d, 1);
    chk(sof_irq == 1'b0, "R11 masked irq", sof_irq, 0);
    wr(4'd5, 32'h1);
    chk(sof_irq == 1'b1, "R11 irq after enable", sof_irq, 1);
    rd(4'd7, d); chk(d == 32'h1, "R11 mask readback", d, 1);
    rd(4'd5, d); chk(d == 32'h0, "R12 enable word reads zero", d, 0);
    wr(4'd8, 32'h0);
    rd(4'd8, d); chk(d == 32'h1, "R10 write zero keeps status", d, 1);
    wr(4'd8, 32'h1);
    chk(sof_irq == 1'b0, "R10 clear drops irq", sof_irq, 0);
    wait_fs(1'b0);
    chk(sof_irq == 1'b0, "R10 status not yet set on first cycle", sof_irq, 0);
    @(negedge clk);
    chk(sof_irq == 1'b1, "R10 status set one cycle later", sof_irq, 1);
    wr(4'd6, 32'h1);
    chk(sof_irq == 1'b0, "R11 irq after disable", sof_irq, 0);
    rd(4'd7, d); chk(d == 32'h0, "R11 mask cleared", d, 0);
    rd(4'd8, d); chk(d == 32'h1, "R11 disable keeps status", d, 1);
    rd(4'd6, d); chk(d == 32'h0, "R12 disable word reads zero", d, 0);
    wr(4'd8, 32'h1);
    rd(4'd8, d); chk(d == 32'h0, "R10 cleared", d, 0);

    // output configuration fields
    wr(4'd4, 32'h0000_0D00);
    chk(out_mode == 3'd5, "R8 mode code", out_mode, 5);
    chk(out_dpi == 1'b1, "R8 interface flag", out_dpi, 1);
    rd(4'd4, d); chk(d == 32'h0000_0D00, "R12 config readback", d, 32'h0000_0D00);
    wr(4'd4, 32'hFFFF_F000);
    rd(4'd4, d); chk(d == 32'h0, "R12 undefined config bits read zero", d, 0);

    // reprogram mid-frame: hs 3, vs 2, vfp 2, vbp 0 (raw), hfp 1, hbp 4, 5 x 3
    wait_fs(1'b0);
    t0 = cyc;
    wr(4'd0, 32'h0001_0002);  // R1
    wr(4'd1, 32'h0000_0001);  // R2: back porch of zero lines, stored raw
    wr(4'd2, 32'h0003_0000);  // R3
    wr(4'd3, 32'h0002_0004);  // R4
    rd(4'd0, d); chk(d == 32'h0001_0002, "R12 pending readback", d, 32'h0001_0002);
    wait_fs(1'b0);
    chk((cyc - t0) == 98, "R9 running frame keeps old length", cyc - t0, 98);
    push_frame(5, 3);
    measure(3, 4, 5, 1, 2, 0, 3, 2, 1'b0, 1'b0, "R1 R2 R3 R4 reprogrammed");

    // inverted polarities
    wr(4'd4, 32'h0000_0003);
    wait_fs(1'b1);
    chk(lcd_hsync == 1'b0, "R7 hsync active low", lcd_hsync, 0);
    chk(lcd_vsync == 1'b0, "R7 vsync active low", lcd_vsync, 0);
    chk(out_mode == 3'd0 && out_dpi == 1'b0, "R8 fields rewritten", out_mode, 0);
    push_frame(5, 3);
    measure(3, 4, 5, 1, 2, 0, 3, 2, 1'b1, 1'b1, "R7 inverted");

    summary();
    $finish;
  end

endmodule